// File: doc/BRIEF.md
# Priority Throttle Arbiter with Dual Pulse Skippers

This block reduces the effective clock rate of a CPU domain and a GPU domain while one or more throttle events are raised. There are three event inputs: a light thermal event, a heavy thermal event and an overcurrent event. Each event has its own priority, a CPU suppression depth and a GPU suppression level. A priority picker chooses one active event. The whole settings bundle of the chosen event then drives two pulse skippers. Each skipper removes a share of the incoming clock-enable strobes.

Each skipper works in windows of 100 incoming enable strobes. For a depth of N percent it removes exactly N strobes per window, spread evenly by a modulo-100 accumulator. A new depth is adopted only on the first strobe of a window, so a change of winner never cuts a window short. The CPU depth is given as a percentage by default. A mode input selects a 2-bit level code for the CPU instead, using the same code table as the GPU.

Top module: `thr_arb_top`

## Requirements
- R1: The winner outputs `win_valid`/`win_idx` are registered. One clock after the request pattern is applied, they name the requesting event whose priority is numerically largest.
- R2: When several requesting events share the largest priority, the one with the lowest index wins.
- R3: With no request, `win_valid` is 0 and `win_idx` is 0 one clock later. From the next window start, both skippers pass every enable strobe. After reset the winner is invalid and both skippers pass every strobe.
- R4: For a depth of N percent, strobe k of a window (k = 0..99) is removed exactly when floor((k+1)N/100) > floor(kN/100). This removes N strobes per window.
- R5: A CPU percentage above 100 behaves as 100, so every CPU strobe is removed.
- R6: The GPU level code maps 0 to 0%, 1 to 50%, 2 to 75% and 3 to 85%.
- R7: With `cpu_lvl_mode` = 1, the CPU depth comes from the winner's `ev_cpu_lvl` code through the mapping of R6 instead of from `ev_cpu_pct`.
- R8: A window is 100 consecutive input strobes, counted per skipper from reset. The depth is taken from the registered winner on the first strobe of a window and held for the rest of that window.
- R9: An output strobe is never high while its input strobe is low. Cycles with the input strobe low do not advance the window or the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_req | input | NUM_EV | Event request lines, bit i for event i (0 light, 1 heavy, 2 overcurrent) |
| ev_prio | input | NUM_EV*PRIO_W | Priority of event i in bits [i*PRIO_W +: PRIO_W] |
| ev_cpu_pct | input | NUM_EV*PCT_W | CPU suppression percentage per event |
| ev_cpu_lvl | input | NUM_EV*LVL_W | CPU level code per event, used when cpu_lvl_mode is 1 |
| ev_gpu_lvl | input | NUM_EV*LVL_W | GPU level code per event |
| cpu_lvl_mode | input | 1 | 1 selects level codes for the CPU depth |
| cpu_en_in | input | 1 | Incoming CPU clock-enable strobe |
| gpu_en_in | input | 1 | Incoming GPU clock-enable strobe |
| cpu_en_out | output | 1 | CPU strobe after skipping |
| gpu_en_out | output | 1 | GPU strobe after skipping |
| win_valid | output | 1 | An event is currently selected |
| win_idx | output | IDX_W | Index of the selected event |

## Verification
The per-window count assertion assumes that the depth fed to a skipper is 100 or less and that priorities are within 1 to 100. The CPU percentage is saturated before it reaches a skipper, so the out-of-range percentage in the stimulus stays legal there. The stimulus changes requests, mode and configuration only at the middle of a window, at least one clock before the next window start. Because of this, the depth expected for each window follows from the request state alone. Gaps in the enable strobes are inserted inside windows to show that they neither advance the window nor produce output strobes.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int WIN_LEN = 100;
    localparam int PCT_W   = 7;
    localparam int LVL_W   = 2;
    localparam int PRIO_W  = 7;

    // level code to suppression percentage
    function automatic logic [PCT_W-1:0] lvl_to_pct(input logic [LVL_W-1:0] code);
        case (code)
            2'd1:    return PCT_W'(50);
            2'd2:    return PCT_W'(75);
            2'd3:    return PCT_W'(85);
            default: return '0;
        endcase
    endfunction

    function automatic logic [PCT_W-1:0] sat_pct(input logic [PCT_W-1:0] raw);
        return (int'(raw) > WIN_LEN) ? PCT_W'(WIN_LEN) : raw;
    endfunction
endpackage

// File: rtl/thr_prio_pick.sv
module thr_prio_pick #(
    parameter int NUM_EV = 3,
    parameter int PRIO_W = 7,
    localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic [NUM_EV-1:0]        req,
    input  logic [NUM_EV*PRIO_W-1:0] prio,
    output logic                     valid,
    output logic [IDX_W-1:0]         idx
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            // strict compare keeps the lower index on a tie
            if (req[i] && (!valid || prio[i*PRIO_W +: PRIO_W] > best)) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/thr_skipper.sv
module thr_skipper
    import thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PCT_W-1:0] pend_depth,
    input  logic             en_in,
    output logic             en_out
);
    typedef struct packed {
        logic [PCT_W-1:0] cnt;
        logic [PCT_W-1:0] acc;
        logic [PCT_W-1:0] depth;
        logic [PCT_W-1:0] sup_cnt;
    } skip_st_t;

    skip_st_t st_q, st_d;
    logic [PCT_W-1:0] eff;
    logic [PCT_W:0]   sum;
    logic             sup;

    always_comb begin
        st_d = st_q;
        eff  = (st_q.cnt == '0) ? pend_depth : st_q.depth;
        sum  = {1'b0, st_q.acc} + {1'b0, eff};
        sup  = (int'(sum) >= WIN_LEN);
        if (en_in) begin
            st_d.cnt = (int'(st_q.cnt) == WIN_LEN - 1) ? '0 : st_q.cnt + 1'b1;
            st_d.acc = sup ? PCT_W'(int'(sum) - WIN_LEN) : sum[PCT_W-1:0];
            if (st_q.cnt == '0) begin
                st_d.depth   = pend_depth;
                st_d.sup_cnt = PCT_W'(sup);
            end else begin
                st_d.sup_cnt = st_q.sup_cnt + PCT_W'(sup);
            end
        end
        en_out = en_in && !sup;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the last strobe of a window completes exactly depth removals
    p_exact_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_in && int'(st_q.cnt) == WIN_LEN - 1) |-> (st_q.sup_cnt + PCT_W'(sup)) == st_q.depth);
    // R9: no output strobe without an input strobe
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |-> !en_out);
    // R9: idle cycles freeze the window position
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |=> $stable(st_q.cnt) && $stable(st_q.acc));
    // R8: depth only reloads on the first strobe of a window
    p_depth_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_in && st_q.cnt == '0) |=> $stable(st_q.depth));
    // R3: zero effective depth passes every strobe
    p_pass_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_in && eff == '0) |-> en_out);
endmodule

// File: rtl/thr_arb_top.sv
module thr_arb_top
    import thr_pkg::*;
#(
    parameter int NUM_EV = 3,
    localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EV-1:0]        ev_req,
    input  logic [NUM_EV*PRIO_W-1:0] ev_prio,
    input  logic [NUM_EV*PCT_W-1:0]  ev_cpu_pct,
    input  logic [NUM_EV*LVL_W-1:0]  ev_cpu_lvl,
    input  logic [NUM_EV*LVL_W-1:0]  ev_gpu_lvl,
    input  logic                     cpu_lvl_mode,
    input  logic                     cpu_en_in,
    input  logic                     gpu_en_in,
    output logic                     cpu_en_out,
    output logic                     gpu_en_out,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } win_t;

    win_t             win_q, win_d;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic [PCT_W-1:0] cpu_pct_tab [NUM_EV];
    logic [PCT_W-1:0] gpu_pct_tab [NUM_EV];
    logic [PCT_W-1:0] cpu_pend, gpu_pend;

    thr_prio_pick #(.NUM_EV(NUM_EV), .PRIO_W(PRIO_W)) u_pick (
        .req   (ev_req),
        .prio  (ev_prio),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    // per-event effective depths
    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        assign cpu_pct_tab[g] = cpu_lvl_mode ? lvl_to_pct(ev_cpu_lvl[g*LVL_W +: LVL_W])
                                             : sat_pct(ev_cpu_pct[g*PCT_W +: PCT_W]);
        assign gpu_pct_tab[g] = lvl_to_pct(ev_gpu_lvl[g*LVL_W +: LVL_W]);
    end

    always_comb begin
        win_d.valid = pick_valid;
        win_d.idx   = pick_idx;
        cpu_pend    = '0;
        gpu_pend    = '0;
        if (win_q.valid) begin
            cpu_pend = cpu_pct_tab[win_q.idx];
            gpu_pend = gpu_pct_tab[win_q.idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_valid = win_q.valid;
    assign win_idx   = win_q.idx;

    thr_skipper u_cpu_skip (
        .clk(clk), .rst_n(rst_n), .pend_depth(cpu_pend),
        .en_in(cpu_en_in), .en_out(cpu_en_out)
    );
    thr_skipper u_gpu_skip (
        .clk(clk), .rst_n(rst_n), .pend_depth(gpu_pend),
        .en_in(gpu_en_in), .en_out(gpu_en_out)
    );

    // R1: any request yields a valid winner next cycle
    p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_req != '0) |=> win_valid);
    // R1: the registered winner was requesting
    p_winner_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_req != '0) |=> ((($past(ev_req)) >> win_idx) & NUM_EV'(1)) != '0);
    // R3: no request yields no winner next cycle
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_req == '0) |=> (!win_valid && win_idx == '0));
endmodule

// File: tb/thr_arb_top_tb_top.sv
module thr_arb_top_tb_top;
    import thr_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NEV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NEV-1:0]        ev_req = '0;
    logic [NEV*PRIO_W-1:0] ev_prio = '0;
    logic [NEV*PCT_W-1:0]  ev_cpu_pct = '0;
    logic [NEV*LVL_W-1:0]  ev_cpu_lvl = '0;
    logic [NEV*LVL_W-1:0]  ev_gpu_lvl = '0;
    logic cpu_lvl_mode = 1'b0;
    logic en_in = 1'b0;
    logic cpu_en_out, gpu_en_out, win_valid;
    logic [1:0] win_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    c;
        bit    g;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_arb_top #(.NUM_EV(NEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_prio(ev_prio),
        .ev_cpu_pct(ev_cpu_pct), .ev_cpu_lvl(ev_cpu_lvl), .ev_gpu_lvl(ev_gpu_lvl),
        .cpu_lvl_mode(cpu_lvl_mode), .cpu_en_in(en_in), .gpu_en_in(en_in),
        .cpu_en_out(cpu_en_out), .gpu_en_out(gpu_en_out),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    function automatic int model_win(input logic [NEV-1:0] r);
        int w = -1;
        int bp = -1;
        for (int i = 0; i < NEV; i++)
            if (r[i] && int'(ev_prio[i*PRIO_W +: PRIO_W]) > bp) begin
                w = i;
                bp = int'(ev_prio[i*PRIO_W +: PRIO_W]);
            end
        return w;
    endfunction

    function automatic int model_lvl(input int code);
        case (code)
            1: return 50;
            2: return 75;
            3: return 85;
            default: return 0;
        endcase
    endfunction

    function automatic bit model_sup(input int k, input int n);
        return ((k + 1) * n) / 100 > (k * n) / 100;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic arb_case(input logic [NEV-1:0] r, input string tag);
        int w;
        @(negedge clk);
        ev_req = r;
        w = model_win(r);
        @(negedge clk);
        check(win_valid == (w >= 0), {tag, " valid"}, int'(win_valid), int'(w >= 0));
        check(int'(win_idx) == ((w < 0) ? 0 : w), {tag, " idx"}, int'(win_idx), (w < 0) ? 0 : w);
    endtask

    // drive one window of 100 strobes; changes land at k==50
    task automatic run_window(input logic [NEV-1:0] nreq, input bit nmode, input bit gappy,
                              input string tag);
        int w, cd, gd;
        item_t it;
        w  = model_win(ev_req);
        cd = 0;
        gd = 0;
        if (w >= 0) begin
            gd = model_lvl(int'(ev_gpu_lvl[w*LVL_W +: LVL_W]));
            if (cpu_lvl_mode) cd = model_lvl(int'(ev_cpu_lvl[w*LVL_W +: LVL_W]));
            else begin
                cd = int'(ev_cpu_pct[w*PCT_W +: PCT_W]);
                if (cd > 100) cd = 100;
            end
        end
        for (int k = 0; k < 100; k++) begin
            if (gappy && (k % 7 == 3)) begin
                @(negedge clk);
                en_in = 1'b0;
                it.c = 1'b0; it.g = 1'b0; it.tag = {tag, " gap R9"};
                sb_q.push_back(it);
            end
            @(negedge clk);
            en_in = 1'b1;
            if (k == 50) begin
                ev_req = nreq;
                cpu_lvl_mode = nmode;
            end
            it.c = !model_sup(k, cd);
            it.g = !model_sup(k, gd);
            it.tag = tag;
            sb_q.push_back(it);
        end
        @(negedge clk);
        en_in = 1'b0;
        it.c = 1'b0; it.g = 1'b0; it.tag = {tag, " tail R9"};
        sb_q.push_back(it);
    endtask

    // monitor
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(cpu_en_out == it.c, {it.tag, " cpu"}, int'(cpu_en_out), int'(it.c));
                check(gpu_en_out == it.g, {it.tag, " gpu"}, int'(gpu_en_out), int'(it.g));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // light 80/50%/lvl1, heavy 100/85%/lvl3, overcurrent 50/75%/lvl2
        ev_prio[0*PRIO_W +: PRIO_W] = 7'd80;
        ev_prio[1*PRIO_W +: PRIO_W] = 7'd100;
        ev_prio[2*PRIO_W +: PRIO_W] = 7'd50;
        ev_cpu_pct[0*PCT_W +: PCT_W] = 7'd50;
        ev_cpu_pct[1*PCT_W +: PCT_W] = 7'd85;
        ev_cpu_pct[2*PCT_W +: PCT_W] = 7'd75;
        ev_gpu_lvl = {2'd2, 2'd3, 2'd1};
        ev_cpu_lvl = {2'd3, 2'd2, 2'd1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        check(!win_valid, "R3 reset valid", int'(win_valid), 0);
        check(win_idx == '0, "R3 reset idx", int'(win_idx), 0);

        // R1 arbitration
        arb_case(3'b001, "R1 light only");
        arb_case(3'b011, "R1 heavy over light");
        arb_case(3'b101, "R1 light over oc");
        arb_case(3'b100, "R1 oc only");
        arb_case(3'b000, "R3 none");
        // R2 ties
        ev_prio[2*PRIO_W +: PRIO_W] = 7'd80;
        arb_case(3'b101, "R2 tie 0/2");
        ev_prio[1*PRIO_W +: PRIO_W] = 7'd80;
        arb_case(3'b110, "R2 tie 1/2");
        arb_case(3'b111, "R2 tie all");
        ev_prio[1*PRIO_W +: PRIO_W] = 7'd100;
        ev_prio[2*PRIO_W +: PRIO_W] = 7'd50;
        arb_case(3'b000, "R3 none again");

        // streaming windows, checked by the monitor
        run_window(3'b001, 1'b0, 1'b0, "R3 idle pass");
        run_window(3'b011, 1'b0, 1'b0, "R4 R6 light 50/50");
        ev_cpu_pct[2*PCT_W +: PCT_W] = 7'd127;
        run_window(3'b100, 1'b0, 1'b0, "R1 R8 heavy 85/85");
        run_window(3'b100, 1'b1, 1'b0, "R5 oc sat 100/75");
        run_window(3'b000, 1'b0, 1'b1, "R7 oc level 85/75");
        run_window(3'b010, 1'b0, 1'b1, "R3 R9 idle gaps");
        run_window(3'b000, 1'b0, 1'b0, "R4 heavy again");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule